// File: doc/BRIEF.md
# Serial Link Frame Receiver with Lock Tracking

This block sits behind the clock-recovery stage of a high-speed serial receiver. It takes one recovered bit per clock and finds where each 40-bit frame begins by checking the frame headers. It then rebuilds the 36-bit payload word and hands it on with a one-cycle write strobe. It keeps its own view of whether the link is locked. Any illegal header, and any parity mismatch on a payload word, drops lock and flags an error. A level output changes state for every payload frame that carries the mark.

A frame goes out most significant bit first. In order, it holds: a 2-bit header, an invert bit, the parity bit, and the 36 data bits from bit 35 down to bit 0. The headers mean the following: `10` is a plain payload word, `11` is a marked payload word, `01` is a filler frame that keeps the link busy, and `00` is illegal.

Top module: `lnk_deframer`

## Requirements
- R1: While `rst_n` is low, the outputs are as follows: `sync_n_o`=1, `perr_n_o`=1, `flag_o`=0, `rx_wr_o`=0, `rx_data_o`=0, `rx_par_o`=0.
- R2: In search mode, the block tries one bit alignment at a time. It declares lock (`sync_n_o` goes low) right after the fourth consecutive frame at that alignment whose header is not `00`. The frame that completes the lock is not delivered.
- R3: While locked, each payload frame (header `10` or `11`) raises `rx_wr_o` for exactly one clock. This happens in the second clock after the frame's last bit is sampled. `rx_data_o` and `rx_par_o` update in that same clock. `rx_par_o` carries the received parity bit, and `rx_wr_o` stays low in every other clock.
- R4: If a frame's invert bit is 1, its 36-bit data field is complemented before output and before the parity check.
- R5: Parity is even over the restored word: the XOR of the 36 data bits must equal the parity bit. On a mismatch while locked, the word is still delivered with its strobe. In that same clock, `sync_n_o` goes high and `perr_n_o` goes low for exactly 40 clocks.
- R6: A `00` header while locked produces no strobe. In the following clock, `sync_n_o` goes high and `perr_n_o` goes low for exactly one clock.
- R7: A filler frame (header `01`) produces no strobe, leaves `rx_data_o`, `rx_par_o` and `flag_o` unchanged, and does not disturb lock.
- R8: `flag_o` toggles together with the strobe of every delivered frame that has header `11`, and changes at no other time.
- R9: After an error, the search starts again at the current alignment. If the next four headers are legal, lock returns right after the fourth of them.
- R10: `rst_n` is asynchronous: pulling it low clears the outputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_i | input | 1 | Recovered serial bit |
| rx_data_o | output | 36 | Restored payload word |
| rx_par_o | output | 1 | Received parity bit of the word |
| rx_wr_o | output | 1 | One-clock write strobe per delivered word |
| sync_n_o | output | 1 | Low while locked to the frame stream |
| perr_n_o | output | 1 | Low during an error indication |
| flag_o | output | 1 | Toggles on each marked frame |

## Verification
The assertions check the rules that hold on every clock:
- a strobe only follows a locked cycle and never lasts two clocks;
- the word is held between strobes;
- the flag changes only with a strobe;
- every loss of lock comes with an error indication, and lock never coexists with that indication.

Other behaviour depends on the bit stream, so only the bench's scenarios can show it:
- the exact clock of each strobe relative to the frame;
- re-inversion and the parity sense;
- the 40-clock versus 1-clock error widths;
- relock exactly four frames after an error;
- the asynchronous clear.

// File: rtl/lnk_pkg.sv
// Shared types for the serial frame receiver.
package lnk_pkg;
    // Two-bit frame header codes; the receiver decodes these positions.
    typedef enum logic [1:0] {
        HDR_BAD   = 2'b00,
        HDR_FILL  = 2'b01,
        HDR_WORD  = 2'b10,
        HDR_MARK  = 2'b11
    } hdr_t;

    // Lock tracker states.
    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } sync_st_t;
endpackage

// File: rtl/lnk_shift.sv
// Bit collector: keeps the latest FRAME_W bits and a frame-position counter.
// Assumes one serial bit per clock. edge_o marks the clock in which the
// window holds a whole candidate frame. slip_i, given with edge_o, keeps the
// counter at the end so the next clock tests the window one bit later.
module lnk_shift #(
    parameter int FRAME_W = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_i,
    input  logic               slip_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic               edge_o
);
    localparam int CW = $clog2(FRAME_W);
    localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

    logic [CW-1:0] cnt;

    assign edge_o = (cnt == LAST);

    // Shift in the new bit and advance or hold the frame position.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_o <= '0;
            cnt     <= '0;
        end else begin
            frame_o <= {frame_o[FRAME_W-2:0], ser_i};
            if (edge_o) begin
                cnt <= slip_i ? cnt : '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lnk_decode.sv
// Frame field decoder, purely combinational.
// Layout, MSB first: header[1:0], invert, parity, data[DATA_W-1:0].
// Restores the inverted data and checks even parity on the restored word.
module lnk_decode
    import lnk_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic [DATA_W+3:0] frame_i,
    output logic [DATA_W-1:0] word_o,
    output logic              par_o,
    output logic              hdr_ok_o,
    output logic              is_word_o,
    output logic              is_mark_o,
    output logic              par_ok_o
);
    localparam int FRAME_W = DATA_W + 4;

    hdr_t       hdr;
    logic       inv;
    logic [DATA_W-1:0] raw;

    // Split the frame into its fields and restore the payload.
    always_comb begin
        hdr       = hdr_t'(frame_i[FRAME_W-1 -: 2]);
        inv       = frame_i[FRAME_W-3];
        par_o     = frame_i[FRAME_W-4];
        raw       = frame_i[DATA_W-1:0];
        word_o    = inv ? ~raw : raw;
        hdr_ok_o  = (hdr != HDR_BAD);
        is_word_o = (hdr == HDR_WORD) || (hdr == HDR_MARK);
        is_mark_o = (hdr == HDR_MARK);
        par_ok_o  = ((^word_o) == par_o);
    end
endmodule

// File: rtl/lnk_sync.sv
// Lock tracker. In search mode, counts LOCK_FRAMES legal headers in a row
// before declaring lock, and slips one bit on an illegal header. While
// locked, reports header and parity errors and returns to search mode
// without slipping.
module lnk_sync
    import lnk_pkg::*;
#(
    parameter int LOCK_FRAMES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic hdr_ok_i,
    input  logic is_word_i,
    input  logic par_ok_i,
    output logic slip_o,
    output logic take_o,
    output logic err_par_o,
    output logic err_hdr_o,
    output logic sync_n_o
);
    localparam int GW = $clog2(LOCK_FRAMES + 1);
    localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_FRAMES - 1);

    sync_st_t      st;
    logic [GW-1:0] good;
    logic          locked_edge;

    // Per-frame decisions taken at each frame boundary.
    always_comb begin
        locked_edge = edge_i && (st == ST_LOCK);
        slip_o      = edge_i && (st == ST_HUNT) && !hdr_ok_i;
        err_hdr_o   = locked_edge && !hdr_ok_i;
        err_par_o   = locked_edge && hdr_ok_i && is_word_i && !par_ok_i;
        take_o      = locked_edge && hdr_ok_i && is_word_i;
        sync_n_o    = (st != ST_LOCK);
    end

    // State and good-header count update.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_HUNT;
            good <= '0;
        end else if (edge_i) begin
            case (st)
                ST_HUNT: begin
                    if (!hdr_ok_i) begin
                        good <= '0;
                    end else if (good == GOOD_LAST) begin
                        st   <= ST_LOCK;
                        good <= '0;
                    end else begin
                        good <= good + 1'b1;
                    end
                end
                default: begin
                    if (err_hdr_o || err_par_o) begin
                        st <= ST_HUNT;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/lnk_outreg.sv
// Output stage: registers the delivered word and strobe, toggles the mark
// flag, and shapes the error indication: FRAME_W clocks long for a parity
// error, one clock for a header error.
module lnk_outreg #(
    parameter int DATA_W  = 36,
    parameter int FRAME_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              par_i,
    input  logic              mark_i,
    input  logic              err_par_i,
    input  logic              err_hdr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              par_o,
    output logic              wr_o,
    output logic              flag_o,
    output logic              perr_n_o
);
    localparam int PW = $clog2(FRAME_W);
    localparam logic [PW-1:0] LONG_LEFT = PW'(FRAME_W - 1);

    logic [PW-1:0] pcnt;

    // Deliver the word, strobe and flag toggle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= '0;
            par_o  <= 1'b0;
            wr_o   <= 1'b0;
            flag_o <= 1'b0;
        end else begin
            wr_o <= take_i;
            if (take_i) begin
                data_o <= word_i;
                par_o  <= par_i;
                flag_o <= flag_o ^ mark_i;
            end
        end
    end

    // Error pulse shaping with a down-counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            perr_n_o <= 1'b1;
            pcnt     <= '0;
        end else if (err_par_i) begin
            perr_n_o <= 1'b0;
            pcnt     <= LONG_LEFT;
        end else if (err_hdr_i) begin
            perr_n_o <= 1'b0;
            pcnt     <= '0;
        end else if (pcnt != '0) begin
            pcnt <= pcnt - 1'b1;
        end else begin
            perr_n_o <= 1'b1;
        end
    end
endmodule

// File: rtl/lnk_deframer.sv
// Serial frame receiver top. Assumes a recovered bit clock with one bit per
// clock, and frames of DATA_W+4 bits sent MSB first. Finds frame alignment,
// delivers payload words with a strobe, tracks lock and reports errors.
module lnk_deframer #(
    parameter int DATA_W      = 36,
    parameter int LOCK_FRAMES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_par_o,
    output logic              rx_wr_o,
    output logic              sync_n_o,
    output logic              perr_n_o,
    output logic              flag_o
);
    localparam int FRAME_W = DATA_W + 4;

    logic [FRAME_W-1:0] frame;
    logic               edge_w, slip, take, err_par, err_hdr;
    logic [DATA_W-1:0]  word;
    logic               par, hdr_ok, is_word, is_mark, par_ok;

    lnk_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .ser_i(ser_i), .slip_i(slip),
        .frame_o(frame), .edge_o(edge_w)
    );

    lnk_decode #(.DATA_W(DATA_W)) u_dec (
        .frame_i(frame), .word_o(word), .par_o(par), .hdr_ok_o(hdr_ok),
        .is_word_o(is_word), .is_mark_o(is_mark), .par_ok_o(par_ok)
    );

    lnk_sync #(.LOCK_FRAMES(LOCK_FRAMES)) u_sync (
        .clk(clk), .rst_n(rst_n), .edge_i(edge_w), .hdr_ok_i(hdr_ok),
        .is_word_i(is_word), .par_ok_i(par_ok), .slip_o(slip),
        .take_o(take), .err_par_o(err_par), .err_hdr_o(err_hdr),
        .sync_n_o(sync_n_o)
    );

    lnk_outreg #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_out (
        .clk(clk), .rst_n(rst_n), .take_i(take), .word_i(word),
        .par_i(par), .mark_i(is_mark), .err_par_i(err_par),
        .err_hdr_i(err_hdr), .data_o(rx_data_o), .par_o(rx_par_o),
        .wr_o(rx_wr_o), .flag_o(flag_o), .perr_n_o(perr_n_o)
    );
endmodule

// File: rtl/lnk_deframer_chk.sv
// Port-level rules of the frame receiver, checked every clock.
module lnk_deframer_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] rx_data_o,
    input logic              rx_wr_o,
    input logic              sync_n_o,
    input logic              perr_n_o,
    input logic              flag_o
);
    // R3: a strobe only follows a locked clock.
    assert_strobe_after_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr_o |-> ($past(sync_n_o) == 1'b0));

    // R3: a strobe lasts one clock.
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr_o |=> !rx_wr_o);

    // R7: the word holds between strobes.
    assert_word_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_wr_o |-> $stable(rx_data_o));

    // R8: the flag changes only with a strobe.
    assert_flag_with_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o != $past(flag_o)) |-> rx_wr_o);

    // R5, R6: every loss of lock is reported.
    assert_loss_reported_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n_o) |-> !perr_n_o);

    // R6: no error indication while locked.
    assert_err_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n_o |-> sync_n_o);

    // R2: the frame that completes lock is not delivered.
    assert_lock_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_n_o) |-> (!rx_wr_o && perr_n_o));
endmodule

bind lnk_deframer lnk_deframer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_data_o(rx_data_o), .rx_wr_o(rx_wr_o),
    .sync_n_o(sync_n_o), .perr_n_o(perr_n_o), .flag_o(flag_o)
);

// File: tb/tb_lnk_deframer.sv
// Bench: seeded random frame stream with directed error and edge frames.
module tb_lnk_deframer;
    localparam int DW  = 36;
    localparam int FW  = DW + 4;
    localparam int NF  = 1000;
    localparam int CHK = 590;   // first frame checked as locked
    localparam int EP  = 600;   // parity-corrupt frame
    localparam int EH  = 800;   // illegal-header frame
    localparam int LK  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser = 1'b0;
    logic [DW-1:0] rx_data;
    logic rx_par, rx_wr, sync_n, perr_n, flag;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [FW-1:0] fr [NF];
    logic [DW-1:0] ew [NF];
    logic          ep [NF];
    logic [1:0]    ek [NF];
    logic          ei [NF];

    always #5 clk = ~clk;

    lnk_deframer #(.DATA_W(DW), .LOCK_FRAMES(LK)) dut (
        .clk(clk), .rst_n(rst_n), .ser_i(ser), .rx_data_o(rx_data),
        .rx_par_o(rx_par), .rx_wr_o(rx_wr), .sync_n_o(sync_n),
        .perr_n_o(perr_n), .flag_o(flag)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] mk(input logic [1:0] hdr, input logic inv,
                                         input logic [DW-1:0] w, input logic flip);
        logic [DW-1:0] raw;
        logic p;
        raw = inv ? ~w : w;
        p = (^w) ^ flip;
        return {hdr, inv, p, raw};
    endfunction

    function automatic bit exp_strobe(input int f);
        bit is_w;
        is_w = (ek[f] == 2'b10) || (ek[f] == 2'b11);
        if (f > EP && f <= EP + LK) return 1'b0;
        if (f >= EH && f <= EH + LK) return 1'b0;
        return is_w;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] prev_data;
        logic prev_par, prev_flag, prev_sync;
        void'($urandom(32'd4711));
        for (int f = 0; f < NF; f++) begin
            logic [63:0] t;
            logic [1:0] h;
            logic inv, flip;
            int r;
            t = {$urandom(), $urandom()};
            r = $urandom % 4;
            h = (r == 0) ? 2'b01 : (r == 1) ? 2'b11 : 2'b10;
            inv = 1'($urandom % 2);
            flip = 1'b0;
            if (f == EP) begin h = 2'b10; flip = 1'b1; end
            if (f == CHK + 2) begin h = 2'b10; inv = 1'b1; t = '0; end
            if (f == CHK + 3) begin h = 2'b11; inv = 1'b0; t = '1; end
            if (f == CHK + 4) begin h = 2'b01; end
            if (f == EH) h = 2'b00;
            fr[f] = mk(h, inv, t[DW-1:0], flip);
            ew[f] = t[DW-1:0];
            ep[f] = fr[f][FW-4];
            ek[f] = h;
            ei[f] = inv;
        end

        // R1: state held during reset
        repeat (3) @(negedge clk);
        chk(sync_n == 1'b1 && perr_n == 1'b1, "R1", "status in reset", {sync_n, perr_n}, 2'b11);
        chk(flag == 1'b0 && rx_wr == 1'b0 && rx_par == 1'b0, "R1", "flag/wr/par in reset",
            {flag, rx_wr, rx_par}, 0);
        chk(rx_data == '0, "R1", "data in reset", rx_data, 0);
        rst_n = 1'b1;

        prev_data = rx_data; prev_par = rx_par; prev_flag = flag; prev_sync = sync_n;
        for (int m = 0; m < NF * FW + FW + 2; m++) begin
            @(negedge clk);
            if (m >= FW + 1 && ((m - FW - 1) % FW) == 0 && ((m - FW - 1) / FW) >= CHK) begin
                int f;
                bit sx;
                f = (m - FW - 1) / FW;
                sx = exp_strobe(f);
                if (f == CHK) chk(sync_n == 1'b0, "R2", "locked after search", sync_n, 0);
                if (f == EP) chk(rx_wr && !perr_n && sync_n, "R5", "parity error report",
                                 {rx_wr, perr_n, sync_n}, 3'b101);
                if (f == EH) chk(!rx_wr && !perr_n && sync_n, "R6", "header error report",
                                 {rx_wr, perr_n, sync_n}, 3'b001);
                if (f == EP + LK || f == EH + LK) begin
                    chk(sync_n == 1'b0, "R9", "relock after four frames", sync_n, 0);
                    chk(prev_sync == 1'b1, "R9", "no early relock", prev_sync, 1);
                end
                if (ek[f] == 2'b01)
                    chk(rx_wr == 1'b0, "R7", "filler frame strobe", rx_wr, 0);
                else
                    chk(rx_wr == sx, "R3", "strobe at frame end", rx_wr, sx);
                if (rx_wr && sx) begin
                    if (ei[f]) chk(rx_data == ew[f], "R4", "re-inverted data", rx_data, ew[f]);
                    else       chk(rx_data == ew[f], "R3", "plain data", rx_data, ew[f]);
                    chk(rx_par == ep[f], "R3", "parity bit out", rx_par, ep[f]);
                    chk(flag == (prev_flag ^ (ek[f] == 2'b11)), "R8", "flag toggle",
                        flag, prev_flag ^ (ek[f] == 2'b11));
                end else begin
                    chk(rx_data == prev_data && rx_par == prev_par, "R7", "word held",
                        rx_data, prev_data);
                    chk(flag == prev_flag, "R8", "flag held", flag, prev_flag);
                end
            end else if (m > CHK * FW + FW + 1) begin
                chk(rx_wr == 1'b0, "R3", "no strobe mid-frame", rx_wr, 0);
            end
            if (m == EP * FW + FW + 1 + 39) chk(perr_n == 1'b0, "R5", "error held 40 clocks", perr_n, 0);
            if (m == EP * FW + FW + 1 + 40) chk(perr_n == 1'b1, "R5", "error ends", perr_n, 1);
            if (m == EH * FW + FW + 2) chk(perr_n == 1'b1, "R6", "short error ends", perr_n, 1);
            prev_data = rx_data; prev_par = rx_par; prev_flag = flag; prev_sync = sync_n;
            if (m < NF * FW) ser = fr[m / FW][FW - 1 - (m % FW)];
            else ser = 1'b0;
        end

        // R10: asynchronous clear between clock edges
        @(negedge clk);
        #2 rst_n = 1'b0;
        #1;
        chk(sync_n == 1'b1 && perr_n == 1'b1 && flag == 1'b0 && rx_wr == 1'b0, "R10",
            "async clear status", {sync_n, perr_n, flag, rx_wr}, 4'b1100);
        chk(rx_data == '0, "R10", "async clear data", rx_data, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule